// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for each beat of a four-beat burst into a synchronous memory. When a new burst starts, a start strobe latches the full external address. From then on, the upper address bits are passed through unchanged from that latched value. The lowest bits are rebuilt on every beat from two things: the latched start value and a separate beat index.

The beat index steps once per clock while the active-low advance input is low. While that input is high it holds, which gives a wait cycle with the address unchanged. After the last beat it rolls over to beat zero, so the burst repeats its own addresses instead of stopping.

A static ordering input selects the beat order. With it low, the low bits count upward and wrap. With it high, each beat address is the start value XOR'd with the beat index. A board that ties this input high, or lets a pull-up hold it high, gets interleaved order. The ordering input is not registered: the output follows it combinationally. Chip-select decoding and the storage array sit outside this block.

Top module: `burst_addr_gen`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises with no start strobe, cur_addr is all zeros.
- R2: A cycle with start high makes cur_addr equal to ext_addr from the next clock edge on (beat 0). This replaces any burst already in progress.
- R3: Without a start strobe, cur_addr[ADDR_W-1:2] keeps the value latched at the last start strobe, whatever ext_addr does.
- R4: With order_sel = 0 (linear), the low two bits on beat k are (s + k) mod 4, where s is the latched ext_addr[1:0]. For example, s = 01 gives 01, 10, 11, 00.
- R5: With order_sel = 1 (interleaved), the low two bits on beat k are s XOR k. For example, s = 01 gives 01, 00, 11, 10, and s = 10 gives 10, 11, 00, 01.
- R6: A clock edge with adv_n = 1 and no start strobe leaves the beat index and cur_addr unchanged.
- R7: One advance after beat 3 returns the beat index to 0, so cur_addr is again the burst's first address.
- R8: order_sel acts combinationally. Changing it mid-burst changes cur_addr in the same cycle and keeps the same beat index.
- R9: When start and adv_n = 0 arrive in the same cycle, the start strobe wins and the next beat is beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Latch ext_addr and begin a burst at beat 0 |
| adv_n | input | 1 | Active-low beat advance; high inserts a wait cycle |
| order_sel | input | 1 | 0 = linear wrap order, 1 = XOR interleaved order |
| ext_addr | input | ADDR_W | External start address |
| cur_addr | output | ADDR_W | Address of the current beat |

## Verification
The bench runs full bursts, with a wrap, from odd start values in both orders. A design that swapped the orders, or that added where it should XOR, diverges at the second beat from start 01. It inserts wait cycles while ext_addr changes underneath: a design that drives the upper bits straight from the input, or that advances during a wait, shows the new value. It also issues a start together with an advance, which catches a design that gives the advance priority. Finally, it flips order_sel mid-burst, which exposes a design that registers the ordering input or keeps only a running address instead of a beat index.

// File: rtl/burst_pkg.sv
package burst_pkg;
  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/burst_start_reg.sv
module burst_start_reg #(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] start_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     start_q <= '0;
    else if (start) start_q <= ext_addr;
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              adv_n,
  output logic [BEAT_W-1:0] beat_q
);
  // start has priority over advance; the counter wraps naturally at 2**BEAT_W
  always_ff @(posedge clk) begin
    if (!rst_n)      beat_q <= '0;
    else if (start)  beat_q <= '0;
    else if (!adv_n) beat_q <= beat_q + 1'b1;
  end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_lo,
  input  logic [BEAT_W-1:0] beat,
  input  order_e            order,
  output logic [BEAT_W-1:0] addr_lo
);
  logic [BEAT_W-1:0] lin_lo;
  logic [BEAT_W-1:0] ilv_lo;

  assign lin_lo = start_lo + beat;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
    assign ilv_lo[b] = start_lo[b] ^ beat[b];
  end

  assign addr_lo = (order == ORDER_INTERLEAVE) ? ilv_lo : lin_lo;
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              adv_n,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] cur_addr
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] start_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] addr_lo;
  order_e            order;

  assign order = order_e'(order_sel);

  burst_start_reg #(.ADDR_W(ADDR_W)) u_start (
    .clk(clk), .rst_n(rst_n), .start(start),
    .ext_addr(ext_addr), .start_q(start_q)
  );

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
    .clk(clk), .rst_n(rst_n), .start(start),
    .adv_n(adv_n), .beat_q(beat_q)
  );

  burst_order_map #(.BEAT_W(BEAT_W)) u_map (
    .start_lo(start_q[BEAT_W-1:0]), .beat(beat_q),
    .order(order), .addr_lo(addr_lo)
  );

  assign cur_addr = {start_q[ADDR_W-1 -: UPPER_W], addr_lo};
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              adv_n,
  input logic              order_sel,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [ADDR_W-1:0] cur_addr
);
  // independent tracking of the burst start and beat count, from the ports only
  logic [BEAT_W-1:0] ref_lo;
  logic [BEAT_W-1:0] ref_beat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_lo   <= '0;
      ref_beat <= '0;
    end else if (start) begin
      ref_lo   <= ext_addr[BEAT_W-1:0];
      ref_beat <= '0;
    end else if (!adv_n) begin
      ref_beat <= ref_beat + 1'b1;
    end
  end

  // R2, R9
  a_r2_load_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cur_addr == $past(ext_addr));

  // R3
  a_r3_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> cur_addr[ADDR_W-1:BEAT_W] == $past(cur_addr[ADDR_W-1:BEAT_W]));

  // R6
  a_r6_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && adv_n) |=> (!$stable(order_sel) || $stable(cur_addr)));

  // R4, R7
  a_r4_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !adv_n && !order_sel) |=>
      (order_sel || cur_addr[BEAT_W-1:0] == BEAT_W'($past(cur_addr[BEAT_W-1:0]) + 1'b1)));

  // R5, R8
  a_r5_interleave: assert property (@(posedge clk) disable iff (!rst_n)
    order_sel |-> cur_addr[BEAT_W-1:0] == (ref_lo ^ ref_beat));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .adv_n(adv_n),
  .order_sel(order_sel), .ext_addr(ext_addr), .cur_addr(cur_addr)
);

// File: tb/burst_addr_gen_tb.sv
`timescale 1ns/1ps
module burst_addr_gen_tb;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          adv_n = 1'b1;
  logic          order_sel = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic [AW-1:0] cur_addr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [AW-1:0] exp_q[$];
  string         tag_q[$];

  // bench-side model of the burst
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_beat = '0;

  always #2 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .BEAT_W(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .adv_n(adv_n),
    .order_sel(order_sel), .ext_addr(ext_addr), .cur_addr(cur_addr)
  );

  function automatic logic [AW-1:0] expect_addr(logic [AW-1:0] b, logic [1:0] k, logic md);
    logic [1:0] lo;
    lo = md ? (b[1:0] ^ k) : 2'(b[1:0] + k);
    return {b[AW-1:2], lo};
  endfunction

  task automatic check(logic [AW-1:0] act, logic [AW-1:0] exp, string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: cur_addr=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: set inputs at the falling edge, push the value expected after the next rising edge
  task automatic step(logic ld, logic an, logic [AW-1:0] a, logic md, string tag);
    @(negedge clk);
    start = ld; adv_n = an; ext_addr = a; order_sel = md;
    if (ld) begin m_base = a; m_beat = 2'd0; end
    else if (!an) m_beat = m_beat + 2'd1;
    exp_q.push_back(expect_addr(m_base, m_beat, md));
    tag_q.push_back(tag);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) check(cur_addr, exp_q.pop_front(), tag_q.pop_front());
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check(cur_addr, '0, "R1 in reset");
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1 check(cur_addr, '0, "R1 after reset");

    // linear from 01: 01,10,11,00 then wrap
    step(1, 1, 17'h15A01, 0, "R2 load linear");
    step(0, 0, 17'h15A01, 0, "R4 beat1");
    step(0, 0, 17'h15A01, 0, "R4 beat2");
    step(0, 0, 17'h15A01, 0, "R4 beat3");
    step(0, 0, 17'h15A01, 0, "R7 linear wrap");
    // waits while ext_addr changes
    step(0, 1, 17'h0FFFE, 0, "R6 wait hold");
    step(0, 1, 17'h00003, 0, "R3 upper ignore");
    step(0, 0, 17'h1FFFF, 0, "R3 upper held on advance");

    // interleaved from 01: 01,00,11,10, wrap
    step(1, 1, 17'h0C3F1, 1, "R2 load interleaved");
    step(0, 0, 17'h0C3F1, 1, "R5 beat1");
    step(0, 1, 17'h0C3F1, 1, "R6 wait interleaved");
    step(0, 0, 17'h0C3F1, 1, "R5 beat2");
    step(0, 0, 17'h0C3F1, 1, "R5 beat3");
    step(0, 0, 17'h0C3F1, 1, "R7 interleaved wrap");

    // interleaved from 10: 10,11,00,01
    step(1, 1, 17'h00A52, 1, "R2 load 10");
    step(0, 0, 17'h00A52, 1, "R5 s10 beat1");
    step(0, 0, 17'h00A52, 1, "R5 s10 beat2");
    step(0, 0, 17'h00A52, 1, "R5 s10 beat3");

    // start with advance in the same cycle, mid-burst
    step(0, 0, 17'h00A52, 1, "R7 s10 wrap");
    step(1, 0, 17'h13337, 0, "R9 start beats advance");
    step(0, 0, 17'h13337, 0, "R4 s11 beat1");

    // mode flip mid-burst: start 01, beat 1 -> linear 10, interleaved 00
    step(1, 1, 17'h00005, 0, "R2 load for mode flip");
    step(0, 0, 17'h00005, 0, "R4 s01 beat1");
    @(posedge clk); #1;
    @(negedge clk) order_sel = 1'b1; adv_n = 1'b1; start = 1'b0;
    #0.5 check(cur_addr, 17'h00004, "R8 flip to interleaved");
    @(negedge clk) order_sel = 1'b0;
    #0.5 check(cur_addr, 17'h00006, "R8 flip back to linear");

    repeat (3) @(posedge clk);
    if (exp_q.size() != 0) begin
      n_tests++; n_fail++;
      $display("FAIL scoreboard: %0d left, expected 0", exp_q.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule